// File: doc/BRIEF.md
# Serial Scan Signature Compactor

This block compresses a serial stream of scan-out data, returned from a local scan chain, into a 16-bit signature. Each accepted bit advances a linear-feedback register by one step. The incoming bit is folded into the feedback term, so the final value depends on every bit and on the order in which the bits arrived. The polynomial is x^16 + x^12 + x^3 + x + 1, which is coefficient mask 0x100B when bit 0 is the x^0 term. After the whole chain has been scanned, the signature can be compared off-block with a value computed ahead of time.

The data input is a valid/ready stream. The compactor never applies back-pressure: `in_ready` is high whenever reset is released, and a bit transfers on any rising clock edge where `in_valid` and `in_ready` are both high. A transferred bit changes the signature only while `cmp_en` is high. While `cmp_en` is low, transferred bits are accepted and discarded. A separate readout shift register, built like a data register of a test access port, captures the signature on a capture strobe. It then presents the signature least-significant bit first on a shift strobe. Reading out never changes the compactor state.

Top module: `sig_compactor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sig_q` is 0x0000, the readout register is 0x0000 and `dr_scan_out` is 0.
- R2: On a rising edge with `cmp_en`, `in_valid` and `in_ready` all high, the next signature is formed as follows. Let fb = `sig_q[15]` XOR `in_bit`. The next `sig_q` is `{sig_q[14:0],1'b0}` XOR (fb ? 16'h100B : 16'h0000).
- R3: On a rising edge where `cmp_en` is low or `in_valid` is low, `sig_q` keeps its value.
- R4: `in_ready` is 1 in every cycle after reset is released, so the input is never back-pressured.
- R5: On a rising edge with `dr_capture` high, the readout register loads the value `sig_q` had before that edge. `dr_scan_out` always shows readout bit 0.
- R6: On a rising edge with `dr_shift` high and `dr_capture` low, the readout register shifts right by one, and `dr_scan_in` enters at bit 15. Sixteen shifts after a capture therefore present the signature on `dr_scan_out`, bit 0 first.
- R7: Capture and shift activity on the readout side never changes `sig_q`, including while compaction runs at the same time.
- R8: When `dr_capture` and `dr_shift` are both high, the capture takes priority and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compaction enable |
| in_valid | input | 1 | Scan data bit is valid |
| in_ready | output | 1 | Compactor accepts the bit (always high out of reset) |
| in_bit | input | 1 | Serial scan data bit from the local chain |
| dr_capture | input | 1 | Load the signature into the readout register |
| dr_shift | input | 1 | Shift the readout register one place toward bit 0 |
| dr_scan_in | input | 1 | Serial input entering readout bit 15 |
| dr_scan_out | output | 1 | Serial output, readout bit 0 |
| sig_q | output | 16 | Current signature |

## Verification
The compactor is driven with four kinds of input:
- An all-zero stream from reset, which must leave the signature at zero.
- A single one bit followed by zeros, which exposes the impulse response and so each feedback tap position.
- An all-ones stream, which drives the feedback term continuously.
- A long random stream with random enable and valid gaps, which separates a correct step from one that ignores the data bit, the hold conditions or the tap mask.

Readout is tested in three ways:
- Capture followed by sixteen shifts with random scan-in bits, which tells LSB-first order apart from MSB-first.
- A cycle with capture and shift strobed together, which tests the priority.
- Readout performed while compaction continues, which shows that the two registers are independent.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h100B;
endpackage

// File: rtl/sig_lfsr_core.sv
module sig_lfsr_core #(
  parameter int unsigned WIDTH = sig_pkg::SIG_W,
  parameter logic [WIDTH-1:0] POLY = sig_pkg::SIG_POLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             din,
  output logic [WIDTH-1:0] state_q
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             fb;
  logic [WIDTH-1:0] state_d;

  assign fb = state_q[MSB] ^ din;

  // Galois form: every tap bit XORs in the feedback term.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      if (gi == 0) begin : g_lsb
        assign state_d[gi] = POLY[gi] & fb;
      end else begin : g_up
        assign state_d[gi] = state_q[gi-1] ^ (POLY[gi] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (step_en) state_q <= state_d;
  end
endmodule

// File: rtl/sig_readout_sr.sv
module sig_readout_sr #(
  parameter int unsigned WIDTH = sig_pkg::SIG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             shift,
  input  logic             scan_in,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] sr_q,
  output logic             scan_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (capture) sr_q <= load_val;
    else if (shift) sr_q <= {scan_in, sr_q[WIDTH-1:1]};
  end

  assign scan_out = sr_q[0];
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int unsigned WIDTH = sig_pkg::SIG_W,
  parameter logic [WIDTH-1:0] POLY = sig_pkg::SIG_POLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             dr_capture,
  input  logic             dr_shift,
  input  logic             dr_scan_in,
  output logic             dr_scan_out,
  output logic [WIDTH-1:0] sig_q
);
  logic             rdy_q;
  logic             xfer;
  logic [WIDTH-1:0] rd_q;

  // Ready rises with the first clock out of reset and stays high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;
  assign xfer     = in_valid & rdy_q & cmp_en;

  sig_lfsr_core #(.WIDTH(WIDTH), .POLY(POLY)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (xfer),
    .din     (in_bit),
    .state_q (sig_q)
  );

  sig_readout_sr #(.WIDTH(WIDTH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (dr_capture),
    .shift    (dr_shift),
    .scan_in  (dr_scan_in),
    .load_val (sig_q),
    .sr_q     (rd_q),
    .scan_out (dr_scan_out)
  );
endmodule

// File: rtl/sig_compactor_chk.sv
module sig_compactor_chk #(
  parameter int unsigned WIDTH = sig_pkg::SIG_W,
  parameter logic [WIDTH-1:0] POLY = sig_pkg::SIG_POLY
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_bit,
  input logic             dr_capture,
  input logic             dr_shift,
  input logic             dr_scan_in,
  input logic             dr_scan_out,
  input logic [WIDTH-1:0] sig_q,
  input logic [WIDTH-1:0] rd_q
);
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else seen_clk <= 1'b1;
  end

  // R2: an accepted zero from the zero state stays at zero
  p_zero_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && in_valid && in_ready && !in_bit && sig_q == '0) |=> sig_q == '0);

  // R2: an accepted one from the zero state loads the tap mask
  p_impulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && in_valid && in_ready && in_bit && sig_q == '0) |=> sig_q == POLY);

  // R3: no accepted bit means no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en || !in_valid) |=> $stable(sig_q));

  // R4: no back-pressure after the first clock
  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_clk |-> in_ready);

  // R5: capture presents the old signature LSB on the serial output
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dr_capture |=> dr_scan_out == $past(sig_q[0]));

  // R6: a shift moves the next bit out and takes scan-in at the top
  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_shift && !dr_capture) |=> (dr_scan_out == $past(rd_q[1]) && rd_q[WIDTH-1] == $past(dr_scan_in)));

  // R8: capture wins over shift
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_shift && dr_capture) |=> rd_q == $past(sig_q));
endmodule

bind sig_compactor sig_compactor_chk #(.WIDTH(WIDTH), .POLY(POLY)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_en      (cmp_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_bit      (in_bit),
  .dr_capture  (dr_capture),
  .dr_shift    (dr_shift),
  .dr_scan_in  (dr_scan_in),
  .dr_scan_out (dr_scan_out),
  .sig_q       (sig_q),
  .rd_q        (rd_q)
);

// File: tb/sig_compactor_tb_top.sv
module sig_compactor_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] P = 16'h100B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_en = 0, in_valid = 0, in_bit = 0;
  logic dr_capture = 0, dr_shift = 0, dr_scan_in = 0;
  logic in_ready, dr_scan_out;
  logic [W-1:0] sig_q;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_sig = '0;
  logic [W-1:0] m_rd = '0;
  logic [W-1:0] cap_val;

  always #4 clk = ~clk;

  sig_compactor dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_scan_in(dr_scan_in),
    .dr_scan_out(dr_scan_out), .sig_q(sig_q)
  );

  function automatic logic [W-1:0] step(input logic [W-1:0] s, input logic b);
    logic fb;
    fb = s[W-1] ^ b;
    return {s[W-2:0], 1'b0} ^ (fb ? P : '0);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sample the state left by earlier drives, then drive one new cycle.
  task automatic cycle(input logic en, input logic v, input logic b,
                       input logic cap, input logic sh, input logic si, input string tag);
    check(sig_q == m_sig, {tag, " sig"}, 32'(sig_q), 32'(m_sig));
    check(dr_scan_out == m_rd[0], {tag, " scan_out"}, 32'(dr_scan_out), 32'(m_rd[0]));
    check(in_ready == 1'b1, "R4 ready", 32'(in_ready), 32'd1);
    cmp_en = en; in_valid = v; in_bit = b;
    dr_capture = cap; dr_shift = sh; dr_scan_in = si;
    if (cap) m_rd = m_sig;
    else if (sh) m_rd = {si, m_rd[W-1:1]};
    if (en && v) m_sig = step(m_sig, b);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    #20;
    check(sig_q == '0, "R1 sig in reset", 32'(sig_q), 0);
    check(dr_scan_out == 1'b0, "R1 scan_out in reset", 32'(dr_scan_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sig_q == '0, "R1 sig after reset", 32'(sig_q), 0);

    // All-zero stream keeps zero
    for (int i = 0; i < 20; i++) cycle(1, 1, 0, 0, 0, 0, "R2 zeros");
    // Impulse response
    cycle(1, 1, 1, 0, 0, 0, "R2 impulse");
    check(sig_q == P, "R2 impulse tap mask", 32'(sig_q), 32'(P));
    for (int i = 0; i < 40; i++) cycle(1, 1, 0, 0, 0, 0, "R2 impulse tail");
    // All ones
    for (int i = 0; i < 40; i++) cycle(1, 1, 1, 0, 0, 0, "R2 ones");
    // Hold: enable low with valid data, then valid low with enable high
    for (int i = 0; i < 20; i++) cycle(0, 1, 1'($urandom), 0, 0, 0, "R3 en low");
    for (int i = 0; i < 20; i++) cycle(1, 0, 1'($urandom), 0, 0, 0, "R3 valid low");

    // Random stream with gaps
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 4) != 0, ($urandom % 3) != 0, 1'($urandom), 0, 0, 0, "R2 random");

    // Capture then 16 shifts, LSB first
    cap_val = m_sig;
    cycle(0, 0, 0, 1, 0, 0, "R5 capture");
    for (int i = 0; i < W; i++) begin
      check(dr_scan_out == cap_val[i], "R6 lsb-first order", 32'(dr_scan_out), 32'(cap_val[i]));
      cycle(0, 0, 0, 0, 1, 1'($urandom), "R6 shift");
    end

    // Capture and shift together
    for (int i = 0; i < 30; i++) cycle(1, 1, 1'($urandom), 0, 0, 0, "R2 refill");
    cycle(0, 0, 0, 1, 1, 1, "R8 priority");
    check(dr_scan_out == m_rd[0], "R8 capture won", 32'(dr_scan_out), 32'(m_rd[0]));

    // Readout while compaction runs
    for (int i = 0; i < 400; i++)
      cycle(1, ($urandom % 2) != 0, 1'($urandom), ($urandom % 17) == 0,
            ($urandom % 2) != 0, 1'($urandom), "R7 concurrent");
    cycle(0, 0, 0, 0, 0, 0, "R7 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule